// File: doc/BRIEF.md
# Serial Port Controller with Character FIFOs

This block is an asynchronous serial transmitter and receiver placed behind a small 32-bit word register bus. Software pushes bytes into a 32-deep transmit queue through the transmit holding register and pops received characters from a 64-deep receive queue through the receive buffer register. The line format is always eight data bits, sent least significant bit first. Even parity, a second stop bit and a forced break level are optional.

The receiver oversamples the line at sixteen times the bit rate and takes a majority vote around mid-bit. It flags parity errors, framing errors, breaks and overruns, both as sticky status bits and, optionally, as flags stored with each character. A single level interrupt combines nine status conditions, each gated by its own enable bit. An internal loopback path lets software exercise both halves without external wiring.

Top module: `sio_port`

## Requirements
- R1: After reset the status word reads 0x3060 (TX FIFO empty bit 13, RX FIFO empty bit 12, transmitter idle bit 6, TX ready bit 5), control reads 0, clock control reads the DIV_RESET parameter (14), `irq` is 0 and `txd` is 1.
- R2: Registers are decoded on byte address bits [4:2] with bits [1:0] zero: 0x00 receive buffer, 0x04 transmit holding, 0x08 control, 0x0C status, 0x10 clock control. Control keeps bits 31 and 15:0 and reads them back. Clock control keeps bits [9:0].
- R3: Each serial bit lasts 16×divisor clocks. A frame is a low start bit, eight data bits LSB first, an even parity bit when control bit 10 is set (making the total count of ones even), then one stop bit, or two when control bit 9 is set. Queued characters follow one another with no idle gap.
- R4: A divisor of 0 or 1 stops the bit clock: `txd` stays high and queued characters stay in the TX FIFO.
- R5: The TX FIFO holds 32 characters. A write while it is full is dropped. Status bit 11 shows full, bit 10 shows at least 16 held, bit 5 (TX ready) shows not full, and bit 13 shows empty.
- R6: A received character appears in receive buffer bits [7:0] and is removed by that read. Status bit 4 (RX ready) shows a character is waiting. A start bit that is not low by majority of three samples near mid-bit is discarded.
- R7: A parity mismatch sets status bit 1 and a low stop bit sets bit 2. An all-zero character with low parity and stop bits is a break: it sets bit 3, not bit 2. With control bit 13 set, a receive buffer read also returns break in bit 15, framing in bit 14, parity in bit 13 and overrun in bit 12 for that character; with it clear those bits read 0.
- R8: The RX FIFO holds 64 characters. A character that completes while it is full is dropped and sets status bit 0. Status bit 8 shows full and bit 7 shows at least 32 held.
- R9: Status bits 3..0, and bit 9 (set on any change of the receive line), are sticky and clear when the status word is read.
- R10: While control bit 15 (TX) or bit 14 (RX) is set, that FIFO is held empty. While bit 31 is set, both FIFOs, both serial engines and the sticky bits are held in reset.
- R11: Control bit 12 feeds the transmitter output into the receiver in place of `rxd`.
- R12: Control bit 11 drives `txd` low within two clocks for as long as it is set.
- R13: `irq` is the registered OR of the status conditions ANDed with control enables [8:0]. The enables map as follows: 8 to TX half (status 10), 7 to RX half (7), 6 to transmitter idle (6), 5 to TX ready (5), 4 to RX ready (4), and 3..0 to status 3..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe |
| txd | output | 1 | Serial transmit line, idle high |
| rxd | input | 1 | Serial receive line |
| irq | output | 1 | Level interrupt |

## Verification
The hardest state to reach from the ports is receive overrun. It needs 64 characters waiting and a 65th arriving without the bus popping any of them. The bench reaches it in loopback: it feeds 65 bytes through the 32-deep transmit queue, pacing its writes on the TX ready bit, and then drains the receiver to confirm that exactly the 65th byte was lost. Breaks and bad stop bits are driven bit by bit onto `rxd`. The full transmit queue is reached by stalling the bit clock with a divisor of 1.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam logic [2:0] REG_RXB = 3'd0;
  localparam logic [2:0] REG_TXH = 3'd1;
  localparam logic [2:0] REG_CTL = 3'd2;
  localparam logic [2:0] REG_STA = 3'd3;
  localparam logic [2:0] REG_CLK = 3'd4;

  localparam int C_SRST  = 31;
  localparam int C_TXCLR = 15;
  localparam int C_RXCLR = 14;
  localparam int C_MIRR  = 13;
  localparam int C_LOOP  = 12;
  localparam int C_BRK   = 11;
  localparam int C_PAR   = 10;
  localparam int C_STOP2 = 9;

  localparam logic [31:0] CTL_KEEP = 32'h8000_FFFF;

  typedef struct packed {
    logic       brk;
    logic       frm;
    logic       par;
    logic       ovr;
    logic [7:0] data;
  } rx_word_t;

  function automatic logic maj3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction
endpackage

// File: rtl/sio_fifo.sv
module sio_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= wp + AW'(1);
      if (do_pop)  rp <= rp + AW'(1);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/sio_baud.sv
module sio_baud #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || div < DIV_W'(2)) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div - DIV_W'(1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + DIV_W'(1);
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/sio_tx.sv
module sio_tx (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       par_en,
  input  logic       stop2,
  input  logic       brk,
  input  logic       q_empty,
  input  logic [7:0] q_data,
  output logic       q_pop,
  output logic       busy,
  output logic       txd
);
  typedef enum logic [2:0] {T_IDLE, T_START, T_DATA, T_PAR, T_STOP} tx_st_t;
  tx_st_t     st;
  logic [3:0] tc;
  logic [2:0] bi;
  logic [7:0] sh;
  logic       pbit, second, line;

  assign busy = (st != T_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= T_IDLE; tc <= '0; bi <= '0; sh <= '0;
      pbit <= 1'b0; second <= 1'b0; line <= 1'b1;
      txd <= 1'b1; q_pop <= 1'b0;
    end else begin
      txd   <= line & ~brk;
      q_pop <= 1'b0;
      if (tick) begin
        case (st)
          T_IDLE: begin
            if (!q_empty) begin
              sh <= q_data; pbit <= ^q_data; bi <= '0; tc <= '0;
              line <= 1'b0; q_pop <= 1'b1; st <= T_START;
            end
          end
          T_START: begin
            tc <= tc + 4'd1;
            if (tc == 4'd15) begin
              st <= T_DATA; line <= sh[0];
            end
          end
          T_DATA: begin
            tc <= tc + 4'd1;
            if (tc == 4'd15) begin
              if (bi == 3'd7) begin
                if (par_en) begin
                  st <= T_PAR; line <= pbit;
                end else begin
                  st <= T_STOP; line <= 1'b1; second <= 1'b0;
                end
              end else begin
                bi <= bi + 3'd1; sh <= sh >> 1; line <= sh[1];
              end
            end
          end
          T_PAR: begin
            tc <= tc + 4'd1;
            if (tc == 4'd15) begin
              st <= T_STOP; line <= 1'b1; second <= 1'b0;
            end
          end
          T_STOP: begin
            tc <= tc + 4'd1;
            if (tc == 4'd15) begin
              if (stop2 && !second) begin
                second <= 1'b1;
              end else if (!q_empty) begin
                sh <= q_data; pbit <= ^q_data; bi <= '0;
                line <= 1'b0; q_pop <= 1'b1; st <= T_START;
              end else begin
                st <= T_IDLE;
              end
            end
          end
          default: st <= T_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sio_rx.sv
module sio_rx
  import sio_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  logic     par_en,
  input  logic     rxi,
  output logic     done,
  output rx_word_t word
);
  typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP, R_HOLD} rx_st_t;
  rx_st_t     st;
  logic [3:0] tc;
  logic [2:0] samp, bi;
  logic [7:0] sh;
  logic       pbit, v, is_brk;

  assign v      = maj3(samp);
  assign is_brk = (sh == 8'h00) && !v && (!par_en || !pbit);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= R_IDLE; tc <= '0; samp <= '0; bi <= '0; sh <= '0;
      pbit <= 1'b0; done <= 1'b0; word <= '0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        if (st != R_IDLE && st != R_HOLD) begin
          tc <= tc + 4'd1;
          if (tc >= 4'd7 && tc <= 4'd9) samp <= {samp[1:0], rxi};
        end
        case (st)
          R_IDLE: if (!rxi) begin st <= R_START; tc <= '0; end
          R_START: begin
            if (tc == 4'd10 && v) st <= R_IDLE;
            else if (tc == 4'd15) begin st <= R_DATA; bi <= '0; end
          end
          R_DATA: begin
            if (tc == 4'd10) sh <= {v, sh[7:1]};
            if (tc == 4'd15) begin
              if (bi == 3'd7) st <= par_en ? R_PAR : R_STOP;
              else            bi <= bi + 3'd1;
            end
          end
          R_PAR: begin
            if (tc == 4'd10) pbit <= v;
            if (tc == 4'd15) st <= R_STOP;
          end
          R_STOP: begin
            if (tc == 4'd10) begin
              done      <= 1'b1;
              word.data <= sh;
              word.brk  <= is_brk;
              word.frm  <= !v && !is_brk;
              word.par  <= par_en && (pbit != ^sh) && !is_brk;
              word.ovr  <= 1'b0;
              st        <= v ? R_IDLE : R_HOLD;
            end
          end
          R_HOLD: if (rxi) st <= R_IDLE;
          default: st <= R_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sio_port.sv
module sio_port
  import sio_pkg::*;
#(
  parameter int TX_DEPTH  = 32,
  parameter int RX_DEPTH  = 64,
  parameter int DIV_W     = 10,
  parameter int DIV_RESET = 14,
  localparam int TX_CW    = $clog2(TX_DEPTH) + 1,
  localparam int RX_CW    = $clog2(RX_DEPTH) + 1,
  localparam int RXW      = $bits(rx_word_t)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_req,
  input  logic        bus_we,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        txd,
  input  logic        rxd,
  output logic        irq
);
  logic [31:0]      ctrl_q;
  logic [DIV_W-1:0] div_q;
  logic             eng_rst, tx_clr, rx_clr, hit;
  logic             wr_tx, rd_rx, stat_rd;
  logic             tick, tx_pop, tx_busy, tx_full, tx_empty;
  logic [7:0]       tx_head;
  logic [TX_CW-1:0] tx_cnt;
  logic [RX_CW-1:0] rx_cnt;
  logic             rx_full, rx_empty, rx_done, rx_push;
  rx_word_t         rx_word, rx_in_word, rx_head;
  logic [RXW-1:0]   rx_head_raw;
  logic             rx_meta, rx_sync, rx_in, rx_prev;
  logic             st_brk, st_frm, st_par, st_ovr, st_tog, ovr_pend;
  logic             frm_ev, ovr_ev;
  logic [13:0]      status;
  logic [8:0]       irq_src;

  assign hit     = bus_req && (bus_addr[1:0] == 2'b00);
  assign wr_tx   = hit &&  bus_we && bus_addr[4:2] == REG_TXH;
  assign rd_rx   = hit && !bus_we && bus_addr[4:2] == REG_RXB;
  assign stat_rd = hit && !bus_we && bus_addr[4:2] == REG_STA;

  assign eng_rst = rst | ctrl_q[C_SRST];
  assign tx_clr  = eng_rst | ctrl_q[C_TXCLR];
  assign rx_clr  = eng_rst | ctrl_q[C_RXCLR];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      div_q  <= DIV_W'(DIV_RESET);
    end else if (hit && bus_we) begin
      if (bus_addr[4:2] == REG_CTL) ctrl_q <= bus_wdata & CTL_KEEP;
      if (bus_addr[4:2] == REG_CLK) div_q  <= bus_wdata[DIV_W-1:0];
    end
  end

  sio_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst(eng_rst), .div(div_q), .tick(tick)
  );

  sio_fifo #(.W(8), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .clr(tx_clr), .push(wr_tx), .din(bus_wdata[7:0]),
    .pop(tx_pop), .dout(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  sio_tx u_tx (
    .clk(clk), .rst(eng_rst), .tick(tick),
    .par_en(ctrl_q[C_PAR]), .stop2(ctrl_q[C_STOP2]), .brk(ctrl_q[C_BRK]),
    .q_empty(tx_empty), .q_data(tx_head), .q_pop(tx_pop), .busy(tx_busy), .txd(txd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_meta <= 1'b1; rx_sync <= 1'b1; rx_prev <= 1'b1;
    end else begin
      rx_meta <= rxd; rx_sync <= rx_meta; rx_prev <= rx_in;
    end
  end
  assign rx_in = ctrl_q[C_LOOP] ? txd : rx_sync;

  sio_rx u_rx (
    .clk(clk), .rst(eng_rst), .tick(tick), .par_en(ctrl_q[C_PAR]),
    .rxi(rx_in), .done(rx_done), .word(rx_word)
  );

  assign rx_push = rx_done & ~rx_full;
  assign ovr_ev  = rx_done &  rx_full;
  assign frm_ev  = rx_done &  rx_word.frm;

  always_comb begin
    rx_in_word     = rx_word;
    rx_in_word.ovr = ovr_pend;
  end

  sio_fifo #(.W(RXW), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .clr(rx_clr), .push(rx_done), .din(rx_in_word),
    .pop(rd_rx), .dout(rx_head_raw), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );
  assign rx_head = rx_word_t'(rx_head_raw);

  always_ff @(posedge clk) begin
    if (eng_rst) begin
      st_brk <= 1'b0; st_frm <= 1'b0; st_par <= 1'b0;
      st_ovr <= 1'b0; st_tog <= 1'b0; ovr_pend <= 1'b0;
    end else begin
      st_brk <= (st_brk & ~stat_rd) | (rx_done & rx_word.brk);
      st_frm <= (st_frm & ~stat_rd) | frm_ev;
      st_par <= (st_par & ~stat_rd) | (rx_done & rx_word.par);
      st_ovr <= (st_ovr & ~stat_rd) | ovr_ev;
      st_tog <= (st_tog & ~stat_rd) | (rx_in ^ rx_prev);
      if (ovr_ev)       ovr_pend <= 1'b1;
      else if (rx_push) ovr_pend <= 1'b0;
    end
  end

  assign status = {tx_empty, rx_empty, tx_full,
                   tx_cnt >= TX_CW'(TX_DEPTH / 2), st_tog, rx_full,
                   rx_cnt >= RX_CW'(RX_DEPTH / 2), tx_empty & ~tx_busy,
                   ~tx_full, ~rx_empty, st_brk, st_frm, st_par, st_ovr};

  assign irq_src = {status[10], status[7:0]};

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(irq_src & ctrl_q[8:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (hit && !bus_we) begin
      case (bus_addr[4:2])
        REG_RXB: bus_rdata <= rx_empty ? 32'h0 :
                   {16'h0,
                    ctrl_q[C_MIRR] ? {rx_head.brk, rx_head.frm, rx_head.par, rx_head.ovr} : 4'h0,
                    4'h0, rx_head.data};
        REG_CTL: bus_rdata <= ctrl_q;
        REG_STA: bus_rdata <= {18'h0, status};
        REG_CLK: bus_rdata <= {{(32-DIV_W){1'b0}}, div_q};
        default: bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk #(
  parameter int TX_DEPTH = 32,
  parameter int RX_DEPTH = 64,
  parameter int DIV_W    = 10,
  parameter int TX_CW    = 6,
  parameter int RX_CW    = 7
) (
  input logic             clk,
  input logic             rst,
  input logic [31:0]      ctrl_q,
  input logic [DIV_W-1:0] div_q,
  input logic             tick,
  input logic             irq,
  input logic             txd,
  input logic [TX_CW-1:0] tx_cnt,
  input logic [RX_CW-1:0] rx_cnt,
  input logic             wr_tx,
  input logic             tx_full,
  input logic             tx_clr,
  input logic             tx_pop,
  input logic             stat_rd,
  input logic             frm_ev,
  input logic             st_frm
);
  // R13
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[8:0] == 9'h0) |=> !irq);

  // R5
  tx_bound_chk: assert property (@(posedge clk) disable iff (rst)
    tx_cnt <= TX_CW'(TX_DEPTH));

  // R8
  rx_bound_chk: assert property (@(posedge clk) disable iff (rst)
    rx_cnt <= RX_CW'(RX_DEPTH));

  // R5
  tx_push_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_tx && !tx_full && !tx_clr && !tx_pop) |=> tx_cnt == $past(tx_cnt) + TX_CW'(1));

  // R9
  sticky_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !frm_ev) |=> !st_frm);

  // R4
  stall_chk: assert property (@(posedge clk) disable iff (rst)
    (div_q < DIV_W'(2)) |=> !tick);

  // R12
  break_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[11] && !ctrl_q[31]) |=> !txd);
endmodule

bind sio_port sio_port_chk #(
  .TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH), .DIV_W(DIV_W), .TX_CW(TX_CW), .RX_CW(RX_CW)
) u_chk (
  .clk(clk), .rst(rst), .ctrl_q(ctrl_q), .div_q(div_q), .tick(tick), .irq(irq),
  .txd(txd), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .wr_tx(wr_tx), .tx_full(tx_full),
  .tx_clr(tx_clr), .tx_pop(tx_pop), .stat_rd(stat_rd), .frm_ev(frm_ev), .st_frm(st_frm)
);

// File: tb/sio_port_tb.sv
module sio_port_tb;
  localparam int BIT = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        txd, irq;
  logic        rxd = 1'b1;

  int vectors = 0, errors = 0, cyc = 0;
  bit tx_quiet = 1'b0;
  logic [7:0] txq[$];

  sio_port u_dut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .txd(txd), .rxd(rxd), .irq(irq)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (tx_quiet) begin
      vectors++;
      if (txd !== 1'b1) begin
        errors++;
        $display("FAIL R4 idle line: txd=%b expected 1 at cycle %0d", txd, cyc);
      end
    end
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog: got cycle %0d expected below 190000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_rx(input logic [7:0] d, input bit par_en, input bit par_bad, input bit stop_v);
    @(negedge clk);
    rxd = 1'b0; waitc(BIT);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; waitc(BIT); end
    if (par_en) begin rxd = (^d) ^ par_bad; waitc(BIT); end
    rxd = stop_v; waitc(BIT);
    rxd = 1'b1; waitc(2 * BIT);
  endtask

  task automatic get_tx(input bit par_en, output logic [7:0] d, output bit par, output bit stp, output int t0);
    while (txd !== 1'b0) @(negedge clk);
    t0 = cyc;
    waitc(BIT / 2);
    chk("R3 start bit", {31'h0, txd}, 32'h0);
    for (int i = 0; i < 8; i++) begin waitc(BIT); d[i] = txd; end
    par = 1'b0;
    if (par_en) begin waitc(BIT); par = txd; end
    waitc(BIT); stp = txd;
  endtask

  task automatic tx_and_check(input string tag, input bit par_en, output int t0);
    logic [7:0] d; bit p, s; logic [7:0] e;
    get_tx(par_en, d, p, s, t0);
    e = txq.pop_front();
    chk(tag, {24'h0, d}, {24'h0, e});
    if (par_en) chk("R3 even parity bit", {31'h0, p}, {31'h0, ^e});
    chk("R3 stop bit", {31'h0, s}, 32'h1);
  endtask

  initial begin
    logic [31:0] r;
    int t0, t1;
    waitc(4);
    rst = 1'b0;
    waitc(2);
    tx_quiet = 1'b1;

    // R1 reset state
    rd(5'h0C, r); chk("R1 status", r, 32'h3060);
    rd(5'h08, r); chk("R1 control", r, 32'h0);
    rd(5'h10, r); chk("R1 clock control", r, 32'd14);
    chk("R1 irq", {31'h0, irq}, 32'h0);

    // R2 register decode and readback
    tx_quiet = 1'b0;
    wr(5'h08, 32'hFFFF_FFFF);
    rd(5'h08, r); chk("R2 control readback", r, 32'h8000_FFFF);
    wr(5'h08, 32'h0);
    wr(5'h10, 32'h0000_07FF);
    rd(5'h10, r); chk("R2 clock control width", r, 32'h3FF);
    wr(5'h10, 32'd2);
    waitc(4);
    rd(5'h0C, r);
    tx_quiet = 1'b1;

    // R3 frame format, back-to-back timing
    tx_quiet = 1'b0;
    txq.push_back(8'hA5); wr(5'h04, 32'hA5);
    txq.push_back(8'h3C); wr(5'h04, 32'h3C);
    tx_and_check("R3 data A5", 1'b0, t0);
    tx_and_check("R3 data 3C", 1'b0, t1);
    chk("R3 one stop frame length", t1 - t0, 10 * BIT);
    waitc(3 * BIT);
    wr(5'h08, 32'h0000_0600);
    txq.push_back(8'h07); wr(5'h04, 32'h07);
    txq.push_back(8'h80); wr(5'h04, 32'h80);
    tx_and_check("R3 data 07 parity", 1'b1, t0);
    tx_and_check("R3 data 80 parity", 1'b1, t1);
    chk("R3 parity two stop frame length", t1 - t0, 12 * BIT);
    waitc(3 * BIT);
    wr(5'h08, 32'h0);
    tx_quiet = 1'b1;

    // R6 receive path and glitch rejection
    send_rx(8'h5A, 1'b0, 1'b0, 1'b1);
    rd(5'h0C, r); chk("R6 rx ready set", r & 32'h1010, 32'h0010);
    rd(5'h00, r); chk("R6 rx data", r, 32'h5A);
    rd(5'h0C, r); chk("R6 rx ready clear", r & 32'h1010, 32'h1000);
    @(negedge clk); rxd = 1'b0; waitc(4); rxd = 1'b1;
    waitc(12 * BIT);
    rd(5'h0C, r);
    chk("R6 glitch discarded", r & 32'h1010, 32'h1000);
    chk("R9 toggled set", r & 32'h200, 32'h200);
    rd(5'h0C, r); chk("R9 toggled cleared by read", r & 32'h20F, 32'h0);

    // R7 errors and mirroring
    wr(5'h08, 32'h0000_2400);
    send_rx(8'h33, 1'b1, 1'b1, 1'b1);
    rd(5'h0C, r); chk("R7 parity status", r & 32'hF, 32'h2);
    rd(5'h00, r); chk("R7 parity mirror", r, 32'h2033);
    send_rx(8'h44, 1'b1, 1'b0, 1'b0);
    rd(5'h0C, r); chk("R7 framing status", r & 32'hF, 32'h4);
    rd(5'h00, r); chk("R7 framing mirror", r, 32'h4044);
    @(negedge clk); rxd = 1'b0; waitc(12 * BIT); rxd = 1'b1; waitc(2 * BIT);
    rd(5'h0C, r); chk("R7 break status", r & 32'hF, 32'h8);
    rd(5'h00, r); chk("R7 break mirror", r, 32'h8000);
    rd(5'h0C, r); chk("R9 stickies cleared", r & 32'hF, 32'h0);
    wr(5'h08, 32'h0000_0400);
    send_rx(8'h11, 1'b1, 1'b1, 1'b1);
    rd(5'h0C, r); chk("R7 parity status unmirrored", r & 32'hF, 32'h2);
    rd(5'h00, r); chk("R7 mirror off", r, 32'h11);

    // R11 loopback, R8 overrun
    tx_quiet = 1'b0;
    wr(5'h08, 32'h0000_1000);
    for (int i = 0; i < 5; i++) wr(5'h04, 32'h60 + i);
    waitc(7 * 10 * BIT);
    for (int i = 0; i < 5; i++) begin
      rd(5'h00, r); chk("R11 loopback data", r, 32'h60 + i);
    end
    for (int i = 0; i < 65; i++) begin
      rd(5'h0C, r);
      while (r[5] == 1'b0) rd(5'h0C, r);
      wr(5'h04, i);
    end
    waitc(36 * 10 * BIT);
    rd(5'h0C, r); chk("R8 full half overrun", r & 32'h0181, 32'h0181);
    for (int i = 0; i < 64; i++) begin
      rd(5'h00, r); chk("R8 kept data", r & 32'hFF, i);
    end
    rd(5'h0C, r); chk("R8 drained", r & 32'h1190, 32'h1000);

    // R10 FIFO resets and soft reset
    for (int i = 0; i < 3; i++) wr(5'h04, 32'h20 + i);
    waitc(5 * 10 * BIT);
    rd(5'h0C, r); chk("R10 rx has data", r & 32'h1000, 32'h0);
    wr(5'h08, 32'h0000_5000);
    rd(5'h0C, r); chk("R10 rx clear empties", r & 32'h1000, 32'h1000);
    wr(5'h08, 32'h0000_1000);
    rd(5'h0C, r); chk("R10 rx stays empty", r & 32'h1000, 32'h1000);
    wr(5'h08, 32'h0);
    waitc(2 * BIT);
    tx_quiet = 1'b1;
    wr(5'h10, 32'd1);
    for (int i = 0; i < 4; i++) wr(5'h04, i);
    rd(5'h0C, r); chk("R10 tx queued", r & 32'h2000, 32'h0);
    wr(5'h08, 32'h0000_8000);
    wr(5'h08, 32'h0);
    rd(5'h0C, r); chk("R10 tx clear empties", r & 32'h2000, 32'h2000);
    wr(5'h04, 32'h55);
    wr(5'h08, 32'h8000_0000);
    wr(5'h08, 32'h0);
    rd(5'h0C, r); chk("R10 soft reset empties", r & 32'h3000, 32'h3000);

    // R4 stalled divisor, R5 full TX FIFO
    for (int i = 0; i < 33; i++) begin
      wr(5'h04, 32'h80 + i);
      if (i < 32) txq.push_back(8'(32'h80 + i));
    end
    waitc(2000);
    rd(5'h0C, r); chk("R5 full half not ready", r & 32'h3CF0, 32'h1C00);
    wr(5'h10, 32'd0);
    waitc(500);
    rd(5'h0C, r); chk("R4 divisor 0 holds data", r & 32'h2000, 32'h0);
    tx_quiet = 1'b0;
    wr(5'h10, 32'd2);
    for (int i = 0; i < 32; i++) tx_and_check("R5 queued order", 1'b0, t0);
    waitc(3 * BIT);
    rd(5'h0C, r); chk("R5 33rd write dropped", r & 32'h2060, 32'h2060);
    tx_quiet = 1'b1;

    // R12 break generation
    tx_quiet = 1'b0;
    wr(5'h08, 32'h0000_0800);
    waitc(2);
    chk("R12 break low", {31'h0, txd}, 32'h0);
    waitc(100);
    chk("R12 break held", {31'h0, txd}, 32'h0);
    wr(5'h08, 32'h0);
    waitc(3);
    chk("R12 break released", {31'h0, txd}, 32'h1);
    tx_quiet = 1'b1;

    // R13 interrupt
    rd(5'h0C, r);
    waitc(3);
    chk("R13 no enables", {31'h0, irq}, 32'h0);
    wr(5'h08, 32'h0000_0040);
    waitc(3);
    chk("R13 tx idle source", {31'h0, irq}, 32'h1);
    wr(5'h08, 32'h0000_0010);
    waitc(3);
    chk("R13 rx ready not pending", {31'h0, irq}, 32'h0);
    tx_quiet = 1'b0;
    wr(5'h08, 32'h0000_1010);
    wr(5'h04, 32'h77);
    waitc(12 * BIT);
    chk("R13 rx ready raises", {31'h0, irq}, 32'h1);
    rd(5'h00, r); chk("R13 rx char", r, 32'h77);
    waitc(3);
    chk("R13 drops after read", {31'h0, irq}, 32'h0);
    wr(5'h08, 32'h0000_0100);
    waitc(3);
    chk("R13 tx half not pending", {31'h0, irq}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule